// File: doc/BRIEF.md
# Logic-Element Register with Steered Asynchronous Controls

This block is a bank of logic-element storage bits that share one clock, one clock enable, one synchronous reset and two active-high asynchronous control lines. Each bit also has its own synchronous data input and its own secondary data input. The bank holds one physical flop per bit, and that flop has only an asynchronous set pin and an asynchronous clear pin. A static 3-bit mode input chooses how the two control lines are steered onto those pins, and whether the flop is wrapped in input and output inversion. The wrapping lets a clear pin act as a preset.

The modes provide six behaviours. There is preset alone and there is preset together with clear. The secondary bit can be loaded asynchronously with a clear, with a preset, or on its own. A preset can also be built from the clear pin plus inversion. The remaining encodings give a plain clocked register. While no asynchronous control is in force, every bit captures its data input on an enabled rising edge. The visible output always equals the logical value, including in the modes where the flop stores the complement.

Top module: `lereg_bank`

## Requirements
- R1: Mode 1 (preset only): raising `ctl_a` forces every output bit to 1 at once. `ctl_b` and `sec_d` have no effect in this mode.
- R2: Mode 2 (preset and clear): `ctl_a` forces all outputs to 1, and `ctl_b` forces all outputs to 0.
- R3: Mode 3 (load with clear): `ctl_a` asynchronously copies `sec_d` to `q`, and `ctl_b` forces `q` to 0.
- R4: Mode 4 (load with preset, inverted storage): `ctl_a` asynchronously copies `sec_d` to `q`, and `ctl_b` forces `q` to all ones. Synchronous writes read back as written.
- R5: Mode 5 (load only): `ctl_a` asynchronously copies `sec_d` to `q`. `ctl_b` has no effect.
- R6: Mode 6 (preset from clear with inversion): `ctl_a` forces `q` to all ones. `ctl_b` and `sec_d` have no effect. Synchronous writes read back as written.
- R7: Modes 0 and 7 behave as a plain clocked register, and neither control line has any effect.
- R8: When both control lines are high, the physical clear wins. This gives `q`=0 in modes 2 and 3 and `q`=all ones in mode 4. In modes 1 and 6 the result is all ones, and in mode 5 it is `sec_d`.
- R9: With no asynchronous control in force, `q` takes `d` on a rising `clk` edge while `ce`=1, and holds while `ce`=0.
- R10: After an asynchronous control is released, `q` keeps its forced value until the next enabled rising edge.
- R11: `rst`=1 at a rising edge clears `q` to 0 in every mode. While an asynchronous control is in force, that control wins over `rst`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to logical 0 |
| ce | input | 1 | Clock enable for synchronous capture |
| mode | input | 3 | Static steering mode, encodings 0..7 |
| ctl_a | input | 1 | Asynchronous control line 1 (preset or load), active high |
| ctl_b | input | 1 | Asynchronous control line 2 (clear or preset), active high |
| d | input | WIDTH | Synchronous data per bit |
| sec_d | input | WIDTH | Secondary data used by asynchronous load |
| q | output | WIDTH | Logical stored value per bit |

## Verification
An asynchronous result has no clock in its path. It appears in the same time step as the control change, so the bench checks it half a nanosecond later and well before the next rising edge. A synchronous capture, hold or reset is due at the first rising edge after the inputs are driven. The bench drives on the falling edge and samples at the next falling edge. The bench sets `sec_d` first and changes the control lines half a nanosecond after that. It never releases `ctl_b` alone while `ctl_a` is still high, so each control change produces exactly one result.

// File: rtl/lereg_pkg.sv
package lereg_pkg;
  typedef enum logic [2:0] {
    M_PLAIN     = 3'd0,
    M_PRESET    = 3'd1,
    M_PRE_CLR   = 3'd2,
    M_LOAD_CLR  = 3'd3,
    M_LOAD_PRE  = 3'd4,
    M_LOAD      = 3'd5,
    M_INV_PRE   = 3'd6,
    M_PLAIN_ALT = 3'd7
  } le_mode_e;
endpackage

// File: rtl/lereg_ctl_decode.sv
module lereg_ctl_decode #(
  parameter int WIDTH = 4
) (
  input  logic [2:0]       mode,
  input  logic             ctl_a,
  input  logic             ctl_b,
  input  logic [WIDTH-1:0] sec_d,
  output logic [WIDTH-1:0] phy_set,
  output logic [WIDTH-1:0] phy_clr,
  output logic             inv
);
  import lereg_pkg::*;

  le_mode_e         mode_e;
  logic [WIDTH-1:0] a_vec;
  logic [WIDTH-1:0] b_vec;

  assign mode_e = le_mode_e'(mode);
  assign a_vec  = {WIDTH{ctl_a}};
  assign b_vec  = {WIDTH{ctl_b}};

  always_comb begin
    phy_set = '0;
    phy_clr = '0;
    inv     = 1'b0;
    case (mode_e)
      M_PRESET: begin
        phy_set = a_vec;
      end
      M_PRE_CLR: begin
        phy_set = a_vec;
        phy_clr = b_vec;
      end
      M_LOAD_CLR: begin
        phy_set = a_vec & sec_d;
        phy_clr = (a_vec & ~sec_d) | b_vec;
      end
      M_LOAD_PRE: begin
        inv     = 1'b1;
        phy_set = a_vec & ~sec_d;
        phy_clr = (a_vec & sec_d) | b_vec;
      end
      M_LOAD: begin
        phy_set = a_vec & sec_d;
        phy_clr = a_vec & ~sec_d;
      end
      M_INV_PRE: begin
        inv     = 1'b1;
        phy_clr = a_vec;
      end
      default: begin
        phy_set = '0;
      end
    endcase
  end
endmodule

// File: rtl/lereg_core_ff.sv
module lereg_core_ff (
  input  logic clk,
  input  logic rst,
  input  logic rst_val,
  input  logic ce,
  input  logic d,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or posedge set or posedge clr) begin
    if (clr)       q <= 1'b0;
    else if (set)  q <= 1'b1;
    else if (rst)  q <= rst_val;
    else if (ce)   q <= d;
  end

  // R8: physical clear dominates the set pin
  p_clr_wins_r8: assert property (@(posedge clk) disable iff (rst)
    clr |-> (q == 1'b0));
  p_set_alone_r8: assert property (@(posedge clk) disable iff (rst)
    (set && !clr) |-> (q == 1'b1));
endmodule

// File: rtl/lereg_bank.sv
module lereg_bank #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic [2:0]       mode,
  input  logic             ctl_a,
  input  logic             ctl_b,
  input  logic [WIDTH-1:0] d,
  input  logic [WIDTH-1:0] sec_d,
  output logic [WIDTH-1:0] q
);
  import lereg_pkg::*;

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  le_mode_e         mode_e;
  logic [WIDTH-1:0] phy_set;
  logic [WIDTH-1:0] phy_clr;
  logic [WIDTH-1:0] phy_q;
  logic             inv;

  assign mode_e = le_mode_e'(mode);

  lereg_ctl_decode #(.WIDTH(WIDTH)) u_decode (
    .mode    (mode),
    .ctl_a   (ctl_a),
    .ctl_b   (ctl_b),
    .sec_d   (sec_d),
    .phy_set (phy_set),
    .phy_clr (phy_clr),
    .inv     (inv)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic phy_d;
    assign phy_d = d[i] ^ inv;
    lereg_core_ff u_ff (
      .clk     (clk),
      .rst     (rst),
      .rst_val (inv),
      .ce      (ce),
      .d       (phy_d),
      .set     (phy_set[i]),
      .clr     (phy_clr[i]),
      .q       (phy_q[i])
    );
    assign q[i] = phy_q[i] ^ inv;
  end

  p_preset_only_r1: assert property (@(posedge clk) disable iff (rst)
    (mode_e == M_PRESET && ctl_a) |-> (q == ALL_ONES));
  p_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_e == M_PRE_CLR && ctl_b) |-> (q == '0));
  p_load_clr_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_e == M_LOAD_CLR && ctl_a && !ctl_b) |-> (q == sec_d));
  p_load_pre_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_e == M_LOAD_PRE && ctl_b) |-> (q == ALL_ONES));
  p_load_only_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_e == M_LOAD && ctl_a) |-> (q == sec_d));
  p_inv_pre_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_e == M_INV_PRE && ctl_a) |-> (q == ALL_ONES));
  p_capture_r9: assert property (@(posedge clk) disable iff (rst)
    (!ctl_a && !ctl_b && ce) |=> (q == $past(d) || ctl_a || ctl_b));
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!ctl_a && !ctl_b && !ce) |=> ($stable(q) || ctl_a || ctl_b));
endmodule

// File: tb/lereg_bank_bench.sv
`timescale 1ns/100ps
module lereg_bank_bench;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst, ce, ctl_a, ctl_b;
  logic [2:0]   mode;
  logic [W-1:0] d, sec_d, q, exp_q;
  int           total = 0;
  int           bad = 0;
  bit           done = 1'b0;

  always #2 clk = ~clk;

  lereg_bank #(.WIDTH(W)) u_lereg_bank (
    .clk(clk), .rst(rst), .ce(ce), .mode(mode), .ctl_a(ctl_a),
    .ctl_b(ctl_b), .d(d), .sec_d(sec_d), .q(q)
  );

  // behavioural model of the asynchronous controls, from the requirements
  function automatic logic force_of(input logic [2:0] m, input logic a1,
                                    input logic a2, input logic [W-1:0] sd,
                                    output logic [W-1:0] v);
    v = '0;
    case (m)
      3'd1, 3'd6: begin if (a1) begin v = '1; return 1'b1; end end // R1 R6
      3'd2: begin if (a2) begin v = '0; return 1'b1; end            // R2
                  if (a1) begin v = '1; return 1'b1; end end
      3'd3: begin if (a2) begin v = '0; return 1'b1; end            // R3
                  if (a1) begin v = sd; return 1'b1; end end
      3'd4: begin if (a2) begin v = '1; return 1'b1; end            // R4
                  if (a1) begin v = sd; return 1'b1; end end
      3'd5: begin if (a1) begin v = sd; return 1'b1; end end        // R5
      default: ;                                                    // R7
    endcase
    return 1'b0;
  endfunction

  function automatic string mode_tag(input logic [2:0] m);
    case (m)
      3'd1: return "R1"; 3'd2: return "R2"; 3'd3: return "R3";
      3'd4: return "R4"; 3'd5: return "R5"; 3'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag);
    total++;
    if (q !== exp_q) begin
      bad++;
      $display("FAIL %s mode=%0d q=%b expected=%b t=%0t", tag, mode, q, exp_q, $time);
    end
  endtask

  // called at a falling edge; result sampled at the next falling edge
  task automatic step(input logic [W-1:0] dv, input logic cev, input logic rv,
                      input string tag);
    logic [W-1:0] v;
    d = dv; ce = cev; rst = rv;
    if (force_of(mode, ctl_a, ctl_b, sec_d, v)) exp_q = v;
    else if (rv) exp_q = '0;
    else if (cev) exp_q = dv;
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  // called at a falling edge; result checked well before the rising edge
  task automatic drive_async(input logic a1, input logic a2,
                             input logic [W-1:0] sd, input string tag);
    logic [W-1:0] v;
    sec_d = sd;
    #0.5;
    ctl_a = a1; ctl_b = a2;
    #0.5;
    if (force_of(mode, a1, a2, sd, v)) exp_q = v;
    check(tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired q=%b expected=%b", q, exp_q);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; ce = 1'b0; ctl_a = 1'b0; ctl_b = 1'b0; mode = 3'd0;
    d = '0; sec_d = '0; exp_q = '0;
    @(negedge clk);
    step('0, 1'b0, 1'b1, "R11");
    for (int m = 0; m < 8; m++) begin
      mode = m[2:0];
      for (int p = 0; p < 16; p++) begin
        logic [W-1:0] pv;
        pv = p[W-1:0];
        step(~pv, 1'b1, 1'b1, "R11");                        // reset beats ce
        step(pv, 1'b1, 1'b0, "R9");                          // capture
        step(~pv, 1'b0, 1'b0, "R9");                         // hold
        drive_async(1'b1, 1'b0, pv ^ 4'b0110, mode_tag(mode)); // ctl_a alone
        step(~pv, 1'b1, 1'b0, mode_tag(mode));               // held over edge
        drive_async(1'b0, 1'b0, pv ^ 4'b0110, "R10");        // release
        step(pv, 1'b0, 1'b0, "R10");                         // still held
        drive_async(1'b0, 1'b1, pv, mode_tag(mode));         // ctl_b alone
        step(pv ^ 4'b0001, 1'b1, 1'b0, mode_tag(mode));
        drive_async(1'b0, 1'b0, pv, "R10");
        step(pv, 1'b1, 1'b0, "R9");                          // capture after release
        drive_async(1'b1, 1'b1, ~pv, "R8");                  // both together
        step(pv, 1'b1, 1'b1, "R11");                         // async beats reset
        drive_async(1'b0, 1'b0, ~pv, "R10");
        step(~pv, 1'b1, 1'b0, "R9");
      end
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule